// File: doc/BRIEF.md
# Serial Controller Host Register Front-End

This block sits between a host processor bus and the register set of a serial channel and its DMA engine. Each host read or write is turned into a resolved register select: a space (serial control, DMA transmit copy, DMA receive copy, or data port) plus a five-bit register address. A small register file model stands behind the selects. Scratch registers and the mirrored DMA registers live in one inferred RAM. The command/address and clock-mode registers are held in flops.

After a hardware reset the block is unconfigured. The first host write, whatever its address, is taken as the bus configuration word. That word fixes multiplexed or non-multiplexed addressing and an 8-bit or 16-bit data width until the next hardware reset. In multiplexed mode the address is captured from the shared address/data lines when the address strobe is asserted. In non-multiplexed mode the host first writes a pointer into the command/address register. The following access uses that pointer, and the pointer then returns to zero. With the data/control input high in serial space, a cycle always reaches the data ports and the address is ignored. The block also holds a channel soft-reset flag and gates the transmit and receive clock enables.

Top module: `sc_host_regif`

## Requirements
- R1: After hardware reset, the first write cycle loads the configuration word whatever the address, space or data/control level, and reaches no register (acc_hit stays low). Before that write, a read returns zero with rd_valid and map_err both pulsing.
- R2: Configuration is one-shot. Bit 0 = 1 selects multiplexed mode and bit 1 = 1 selects the 16-bit width. Later writes never change cfg_done, cfg_mux or cfg_wide until hardware reset.
- R3: In multiplexed mode, bus_ad[5:1] is latched as the register address on every cycle with bus_as high. Later accesses use the latched value.
- R4: In serial space (bus_sd=0) with bus_dc=1, the address is ignored. A write pulses tx_push with tx_word = the write data. A read pulses rx_pop and returns rx_word. acc_kind = 3. The non-multiplexed pointer is left unchanged.
- R5: In non-multiplexed mode, a serial write to address 0 while the pointer is zero loads the pointer from write data bits [5:1]. The next non-data-port access uses the pointer as its address, and the pointer then clears to zero. The bus_as input has no effect in this mode.
- R6: Serial register 0 bit 7 sets the channel reset flag (chan_reset). Once the flag is set, only an all-zero write to register 0 clears it. On the 16-bit bus the whole word must be zero. On the 8-bit bus only the lower byte must be zero. Register 0 reads as {chan_reset at bit 7, pointer at bits 5:1}.
- R7: tx_clk_en and rx_clk_en are low after hardware reset. Serial register 1 holds the transmit clock source in bits [1:0] and the receive source in bits [3:2]. Each enable is high exactly when its source field is nonzero.
- R8: With bus_sd=1, addresses 16 to 23 are DMA registers. bus_dc=0 selects the transmit copy (acc_kind 1) and bus_dc=1 selects the receive copy (acc_kind 2). The two copies are stored separately.
- R9: Serial addresses 2 to 7 are read/write scratch registers.
- R10: Unmapped addresses read as zero and ignore writes, with map_err high for exactly one clock. Unmapped means serial addresses 8 to 31 and DMA addresses 0 to 15 and 24 to 31.
- R11: In 8-bit mode, write data bits [15:8] are discarded and read data bits [15:8] are zero.
- R12: acc_hit, acc_kind, acc_addr, rd_valid, rd_data, map_err and the port pulses appear in the clock after the edge that sampled the access. acc_kind encodes 0 = serial control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_as | input | 1 | Address strobe (latches address in multiplexed mode) |
| bus_ad | input | 16 | Shared address/write-data lines |
| bus_rd | input | 1 | Read cycle, one clock |
| bus_wr | input | 1 | Write cycle, one clock |
| bus_sd | input | 1 | Space select: 0 serial, 1 DMA |
| bus_dc | input | 1 | Data/control select |
| rx_word | input | 16 | Receive data presented by the serial engine |
| rd_data | output | 16 | Read data |
| rd_valid | output | 1 | Read data valid pulse |
| acc_hit | output | 1 | Mapped register access pulse |
| acc_kind | output | 2 | Resolved space of the access |
| acc_addr | output | 5 | Resolved register address |
| map_err | output | 1 | Unmapped or unconfigured access pulse |
| tx_push | output | 1 | Transmit data register written |
| tx_word | output | 16 | Transmit data word |
| rx_pop | output | 1 | Receive data register read |
| cfg_done | output | 1 | Configuration word loaded |
| cfg_mux | output | 1 | Multiplexed mode selected |
| cfg_wide | output | 1 | 16-bit width selected |
| chan_reset | output | 1 | Channel soft reset flag |
| tx_clk_en | output | 1 | Transmit clock enable |
| rx_clk_en | output | 1 | Receive clock enable |

## Verification
A stale or wrongly cleared pointer shows on the very next non-multiplexed access: acc_addr reports the wrong register and the read data comes from the wrong place. A configuration flag that is lost or captured twice changes how the following write is routed, so a register select or a cfg output is wrong one clock later. A wrong channel-reset or clock-source state is visible on its own output pin one clock after the write. It can also be read back through register 0 or register 1.

// File: rtl/sc_regif_pkg.sv
`timescale 1ns/1ps
package sc_regif_pkg;
  localparam int AW       = 5;
  localparam int CMD_ADDR = 0;
  localparam int CLK_ADDR = 1;
  localparam int RST_BIT  = 7;

  typedef enum logic [1:0] {
    KIND_SER    = 2'd0,
    KIND_DMA_TX = 2'd1,
    KIND_DMA_RX = 2'd2,
    KIND_PORT   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/sc_regif_decode.sv
`timescale 1ns/1ps
module sc_regif_decode
  import sc_regif_pkg::*;
#(
  parameter int DW       = 16,
  parameter int SER_REGS = 8,
  parameter int DMA_BASE = 16,
  parameter int DMA_REGS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_done,
  input  logic          cfg_mux,
  input  logic          bus_as,
  input  logic [DW-1:0] bus_ad,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          bus_sd,
  input  logic          bus_dc,
  input  logic [AW:1]   ptr_wd,
  output logic          cyc,
  output logic          is_cfg,
  output logic          is_err,
  output logic          hit,
  output acc_kind_e     kind,
  output logic [AW-1:0] eff,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] lat_q;
  logic          port_sel;

  assign cyc      = bus_rd | bus_wr;
  assign eff      = cfg_mux ? lat_q : ptr;
  assign port_sel = !bus_sd && bus_dc;

  always_comb begin
    is_cfg = 1'b0;
    is_err = 1'b0;
    hit    = 1'b0;
    kind   = KIND_SER;
    if (cyc) begin
      if (!cfg_done) begin
        if (bus_wr) is_cfg = 1'b1;
        else        is_err = 1'b1;
      end else if (port_sel) begin
        hit  = 1'b1;
        kind = KIND_PORT;
      end else if (bus_sd) begin
        if (int'(eff) >= DMA_BASE && int'(eff) < DMA_BASE + DMA_REGS) begin
          hit  = 1'b1;
          kind = bus_dc ? KIND_DMA_RX : KIND_DMA_TX;
        end else begin
          is_err = 1'b1;
        end
      end else if (int'(eff) < SER_REGS) begin
        hit = 1'b1;
      end else begin
        is_err = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else if (bus_as) lat_q <= bus_ad[AW:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (cyc && cfg_done && !cfg_mux && !port_sel) begin
      if (!bus_sd && bus_wr && int'(ptr) == CMD_ADDR) ptr <= ptr_wd;
      else ptr <= '0;
    end
  end
endmodule

// File: rtl/sc_regif_ctrl.sv
`timescale 1ns/1ps
module sc_regif_ctrl
  import sc_regif_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_bits,
  input  logic          cmd_we,
  input  logic          clk_we,
  input  logic [DW-1:0] wd,
  output logic          cfg_done,
  output logic          cfg_mux,
  output logic          cfg_wide,
  output logic          chan_rst,
  output logic [3:0]    clk_src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_done <= 1'b0;
      cfg_mux  <= 1'b0;
      cfg_wide <= 1'b0;
    end else if (cfg_we && !cfg_done) begin
      cfg_done <= 1'b1;
      cfg_mux  <= cfg_bits[0];
      cfg_wide <= cfg_bits[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_rst <= 1'b0;
    end else if (cmd_we) begin
      if (chan_rst) begin
        if (wd == '0) chan_rst <= 1'b0;
      end else begin
        chan_rst <= wd[RST_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_src <= '0;
    else if (clk_we) clk_src <= wd[3:0];
  end
endmodule

// File: rtl/sc_regif_store.sv
`timescale 1ns/1ps
module sc_regif_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 24,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= ram[idx];
  end
endmodule

// File: rtl/sc_host_regif.sv
`timescale 1ns/1ps
module sc_host_regif
  import sc_regif_pkg::*;
#(
  parameter int DW       = 16,
  parameter int SER_REGS = 8,
  parameter int DMA_BASE = 16,
  parameter int DMA_REGS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_as,
  input  logic [DW-1:0] bus_ad,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          bus_sd,
  input  logic          bus_dc,
  input  logic [DW-1:0] rx_word,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          acc_hit,
  output logic [1:0]    acc_kind,
  output logic [4:0]    acc_addr,
  output logic          map_err,
  output logic          tx_push,
  output logic [DW-1:0] tx_word,
  output logic          rx_pop,
  output logic          cfg_done,
  output logic          cfg_mux,
  output logic          cfg_wide,
  output logic          chan_reset,
  output logic          tx_clk_en,
  output logic          rx_clk_en
);
  localparam int RAM_DEPTH = SER_REGS + 2 * DMA_REGS;
  localparam int IW        = $clog2(RAM_DEPTH);
  localparam logic [DW-1:0] NARROW_MASK = DW'((1 << (DW / 2)) - 1);

  logic          cyc, is_cfg, is_err, hit;
  acc_kind_e     kind;
  logic [AW-1:0] eff, ptr;
  logic [DW-1:0] mask, wd, cmd_val, rd_hold, ram_q, hold_q;
  logic [3:0]    clk_src;
  logic [IW-1:0] ram_idx;
  logic          ram_sel, ram_we, cmd_we, clk_we, src_ram_q;

  assign mask = cfg_wide ? '1 : NARROW_MASK;
  assign wd   = bus_ad & mask;

  sc_regif_decode #(
    .DW(DW), .SER_REGS(SER_REGS), .DMA_BASE(DMA_BASE), .DMA_REGS(DMA_REGS)
  ) u_dec (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .cfg_mux(cfg_mux),
    .bus_as(bus_as), .bus_ad(bus_ad), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_sd(bus_sd), .bus_dc(bus_dc), .ptr_wd(wd[AW:1]),
    .cyc(cyc), .is_cfg(is_cfg), .is_err(is_err), .hit(hit),
    .kind(kind), .eff(eff), .ptr(ptr)
  );

  assign cmd_we = hit && bus_wr && kind == KIND_SER && int'(eff) == CMD_ADDR;
  assign clk_we = hit && bus_wr && kind == KIND_SER && int'(eff) == CLK_ADDR;

  sc_regif_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(is_cfg), .cfg_bits(bus_ad[1:0]),
    .cmd_we(cmd_we), .clk_we(clk_we), .wd(wd),
    .cfg_done(cfg_done), .cfg_mux(cfg_mux), .cfg_wide(cfg_wide),
    .chan_rst(chan_reset), .clk_src(clk_src)
  );

  assign tx_clk_en = |clk_src[1:0];
  assign rx_clk_en = |clk_src[3:2];

  always_comb begin
    ram_sel = 1'b0;
    ram_idx = '0;
    if (hit && (kind == KIND_DMA_TX || kind == KIND_DMA_RX)) begin
      ram_sel = 1'b1;
      ram_idx = IW'(SER_REGS + (kind == KIND_DMA_RX ? DMA_REGS : 0)
                    + int'(eff) - DMA_BASE);
    end else if (hit && kind == KIND_SER && int'(eff) > CLK_ADDR) begin
      ram_sel = 1'b1;
      ram_idx = IW'(eff);
    end
  end
  assign ram_we = ram_sel && bus_wr;

  sc_regif_store #(.DW(DW), .DEPTH(RAM_DEPTH)) u_store (
    .clk(clk), .we(ram_we), .idx(ram_idx), .wdata(wd), .rdata(ram_q)
  );

  always_comb begin
    cmd_val          = '0;
    cmd_val[RST_BIT] = chan_reset;
    cmd_val[AW:1]    = ptr;
    rd_hold          = '0;
    if (hit && bus_rd) begin
      if (kind == KIND_PORT) rd_hold = rx_word;
      else if (kind == KIND_SER && int'(eff) == CMD_ADDR) rd_hold = cmd_val;
      else if (kind == KIND_SER && int'(eff) == CLK_ADDR) rd_hold = DW'(clk_src);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hit   <= 1'b0;
      acc_kind  <= '0;
      acc_addr  <= '0;
      map_err   <= 1'b0;
      rd_valid  <= 1'b0;
      tx_push   <= 1'b0;
      tx_word   <= '0;
      rx_pop    <= 1'b0;
      src_ram_q <= 1'b0;
      hold_q    <= '0;
    end else begin
      acc_hit   <= hit;
      acc_kind  <= kind;
      acc_addr  <= eff;
      map_err   <= is_err;
      rd_valid  <= cyc && bus_rd;
      tx_push   <= hit && bus_wr && kind == KIND_PORT;
      rx_pop    <= hit && bus_rd && kind == KIND_PORT;
      src_ram_q <= ram_sel && bus_rd;
      hold_q    <= rd_hold;
      if (hit && bus_wr && kind == KIND_PORT) tx_word <= wd;
    end
  end

  assign rd_data = (src_ram_q ? ram_q : hold_q) & mask;
endmodule

// File: rtl/sc_host_regif_chk.sv
`timescale 1ns/1ps
module sc_host_regif_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_hit,
  input logic [1:0] acc_kind,
  input logic [4:0] acc_addr,
  input logic       map_err,
  input logic       tx_push,
  input logic       rx_pop,
  input logic       rd_valid,
  input logic       cfg_done,
  input logic       cfg_mux,
  input logic       cfg_wide,
  input logic       chan_reset,
  input logic       tx_clk_en,
  input logic       rx_clk_en
);
  assert_cfg_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> cfg_done && $stable(cfg_mux) && $stable(cfg_wide));

  assert_no_access_unconfigured_R1: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |=> !acc_hit && !tx_push && !rx_pop);

  assert_clk_off_unconfigured_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |-> !tx_clk_en && !rx_clk_en);

  assert_clk_rise_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_clk_en) |-> acc_hit && acc_kind == 2'd0 && acc_addr == 5'd1);

  assert_err_not_hit_R10: assert property (@(posedge clk) disable iff (rst)
    map_err |-> !acc_hit);

  assert_port_kind_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_push || rx_pop) |-> acc_hit && acc_kind == 2'd3);

  assert_port_read_valid_R12: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> rd_valid);

  assert_chan_reset_by_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(chan_reset) |-> acc_hit && acc_kind == 2'd0 && acc_addr == 5'd0);
endmodule

bind sc_host_regif sc_host_regif_chk u_chk (
  .clk(clk), .rst(rst), .acc_hit(acc_hit), .acc_kind(acc_kind),
  .acc_addr(acc_addr), .map_err(map_err), .tx_push(tx_push), .rx_pop(rx_pop),
  .rd_valid(rd_valid), .cfg_done(cfg_done), .cfg_mux(cfg_mux),
  .cfg_wide(cfg_wide), .chan_reset(chan_reset), .tx_clk_en(tx_clk_en),
  .rx_clk_en(rx_clk_en)
);

// File: tb/sc_host_regif_test.sv
`timescale 1ns/1ps
module sc_host_regif_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_as = 1'b0;
  logic [15:0] bus_ad = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sd = 1'b0;
  logic        bus_dc = 1'b0;
  logic [15:0] rx_word = 16'h5A5A;
  logic [15:0] rd_data, tx_word;
  logic        rd_valid, acc_hit, map_err, tx_push, rx_pop;
  logic [1:0]  acc_kind;
  logic [4:0]  acc_addr;
  logic        cfg_done, cfg_mux, cfg_wide, chan_reset, tx_clk_en, rx_clk_en;

  int vecs = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sc_host_regif uut (
    .clk(clk), .rst(rst), .bus_as(bus_as), .bus_ad(bus_ad), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_sd(bus_sd), .bus_dc(bus_dc), .rx_word(rx_word),
    .rd_data(rd_data), .rd_valid(rd_valid), .acc_hit(acc_hit),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .map_err(map_err),
    .tx_push(tx_push), .tx_word(tx_word), .rx_pop(rx_pop),
    .cfg_done(cfg_done), .cfg_mux(cfg_mux), .cfg_wide(cfg_wide),
    .chan_reset(chan_reset), .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic strobe(input logic [4:0] a);
    bus_as = 1'b1;
    bus_ad = {10'b0, a, 1'b0};
    @(negedge clk);
    bus_as = 1'b0;
    bus_ad = 16'hFFFF;
  endtask

  task automatic wr(input logic sd, input logic dc, input logic [15:0] d);
    bus_wr = 1'b1; bus_sd = sd; bus_dc = dc; bus_ad = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_sd = 1'b0; bus_dc = 1'b0; bus_ad = 16'hFFFF;
  endtask

  task automatic rd(input logic sd, input logic dc);
    bus_rd = 1'b1; bus_sd = sd; bus_dc = dc;
    @(negedge clk);
    bus_rd = 1'b0; bus_sd = 1'b0; bus_dc = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 cfg_done after reset", 16'(cfg_done), 16'h0);
    chk("R6 chan_reset after reset", 16'(chan_reset), 16'h0);
    chk("R7 clocks off after reset", {14'b0, tx_clk_en, rx_clk_en}, 16'h0);
    rd(1'b0, 1'b0);
    chk("R10 unconfigured read data", rd_data, 16'h0);
    chk("R10 unconfigured read err", {14'b0, rd_valid, map_err}, 16'h3);
    chk("R1 still unconfigured after read", 16'(cfg_done), 16'h0);
  endtask

  task automatic t_config_mux();
    strobe(5'd2);
    wr(1'b1, 1'b1, 16'h0003);
    chk("R1 config captured", {13'b0, cfg_done, cfg_mux, cfg_wide}, 16'h7);
    chk("R1 config write reaches no register", 16'(acc_hit), 16'h0);
  endtask

  task automatic t_mux_scratch();
    strobe(5'd3); wr(1'b0, 1'b0, 16'hA5A5);
    strobe(5'd4); wr(1'b0, 1'b0, 16'h1234);
    strobe(5'd3); rd(1'b0, 1'b0);
    chk("R3 R9 scratch 3 readback", rd_data, 16'hA5A5);
    chk("R12 kind/addr of scratch read", {9'b0, acc_hit, acc_kind, acc_addr}, {9'b0, 1'b1, 2'd0, 5'd3});
    strobe(5'd4); rd(1'b0, 1'b0);
    chk("R9 scratch 4 readback", rd_data, 16'h1234);
  endtask

  task automatic t_cfg_locked();
    strobe(5'd2); wr(1'b0, 1'b0, 16'h0000);
    chk("R2 config unchanged by later write", {13'b0, cfg_done, cfg_mux, cfg_wide}, 16'h7);
    chk("R2 later write hits register", 16'(acc_hit), 16'h1);
  endtask

  task automatic t_clock();
    strobe(5'd1); wr(1'b0, 1'b0, 16'h0002);
    chk("R7 tx source set", {14'b0, tx_clk_en, rx_clk_en}, 16'h2);
    wr(1'b0, 1'b0, 16'h0008);
    chk("R7 rx source set", {14'b0, tx_clk_en, rx_clk_en}, 16'h1);
    rd(1'b0, 1'b0);
    chk("R7 clock mode readback", rd_data, 16'h0008);
  endtask

  task automatic t_chan_reset_wide();
    strobe(5'd0); wr(1'b0, 1'b0, 16'h0080);
    chk("R6 enter channel reset", 16'(chan_reset), 16'h1);
    rd(1'b0, 1'b0);
    chk("R6 reset bit readback", rd_data, 16'h0080);
    wr(1'b0, 1'b0, 16'h0100);
    chk("R6 nonzero word keeps reset (16-bit)", 16'(chan_reset), 16'h1);
    wr(1'b0, 1'b0, 16'h0000);
    chk("R6 zero word exits reset", 16'(chan_reset), 16'h0);
  endtask

  task automatic t_dma();
    strobe(5'd21);
    wr(1'b1, 1'b0, 16'h1111);
    chk("R8 tx copy kind", {14'b0, acc_kind}, 16'd1);
    wr(1'b1, 1'b1, 16'h2222);
    chk("R8 rx copy kind", {14'b0, acc_kind}, 16'd2);
    rd(1'b1, 1'b0);
    chk("R8 tx copy readback", rd_data, 16'h1111);
    chk("R12 DMA addr", {11'b0, acc_addr}, 16'd21);
    rd(1'b1, 1'b1);
    chk("R8 rx copy readback", rd_data, 16'h2222);
    rd(1'b0, 1'b0);
    chk("R10 serial addr 21 unmapped", {14'b0, acc_hit, map_err}, 16'h1);
  endtask

  task automatic t_port();
    strobe(5'd3);
    wr(1'b0, 1'b1, 16'hBEEF);
    chk("R4 tx push", {13'b0, tx_push, acc_kind}, {13'b0, 1'b1, 2'd3});
    chk("R4 tx word", tx_word, 16'hBEEF);
    rd(1'b0, 1'b1);
    chk("R4 rx pop", 16'(rx_pop), 16'h1);
    chk("R4 rx data", rd_data, 16'h5A5A);
    rd(1'b0, 1'b0);
    chk("R4 addressed register untouched", rd_data, 16'hA5A5);
  endtask

  task automatic t_unmapped();
    strobe(5'd9);
    wr(1'b0, 1'b0, 16'h7777);
    chk("R10 unmapped write err", {14'b0, acc_hit, map_err}, 16'h1);
    rd(1'b0, 1'b0);
    chk("R10 unmapped read zero", rd_data, 16'h0);
    @(negedge clk);
    chk("R10 err is one clock", 16'(map_err), 16'h0);
    strobe(5'd3); rd(1'b1, 1'b0);
    chk("R10 DMA addr 3 unmapped", {rd_data[14:0], map_err}, 16'h1);
    strobe(5'd24); rd(1'b1, 1'b1);
    chk("R10 DMA addr 24 unmapped", {rd_data[14:0], map_err}, 16'h1);
  endtask

  task automatic t_nonmux();
    hw_reset();
    chk("R1 unconfigured after second reset", 16'(cfg_done), 16'h0);
    wr(1'b0, 1'b0, 16'h0000);
    chk("R2 nonmux narrow config", {13'b0, cfg_done, cfg_mux, cfg_wide}, 16'h4);
    wr(1'b0, 1'b0, 16'hFF06);
    chk("R5 pointer load is not the access", {11'b0, acc_addr}, 16'd0);
    wr(1'b0, 1'b0, 16'h1234);
    chk("R5 indirect write target", {11'b0, acc_addr}, 16'd3);
    strobe(5'd4);
    rd(1'b0, 1'b0);
    chk("R5 pointer cleared, strobe ignored", {11'b0, acc_addr}, 16'd0);
    chk("R5 register 0 reads zero pointer", rd_data, 16'h0);
    wr(1'b0, 1'b0, 16'h0006);
    rd(1'b0, 1'b0);
    chk("R11 narrow write stored low byte", rd_data, 16'h0034);
    wr(1'b0, 1'b0, 16'h0006);
    wr(1'b0, 1'b1, 16'hABCD);
    chk("R11 narrow tx word", tx_word, 16'h00CD);
    chk("R4 data port in nonmux", 16'(tx_push), 16'h1);
    rd(1'b0, 1'b0);
    chk("R4 pointer survives data port", {11'b0, acc_addr}, 16'd3);
    rx_word = 16'hC3A7;
    rd(1'b0, 1'b1);
    chk("R11 narrow read upper byte zero", rd_data, 16'h00A7);
    wr(1'b0, 1'b0, 16'h002A);
    wr(1'b1, 1'b1, 16'h0099);
    chk("R8 indirect DMA rx access", {9'b0, acc_kind, acc_addr}, {9'b0, 2'd2, 5'd21});
    rd(1'b1, 1'b1);
    chk("R5 pointer cleared after DMA access", {14'b0, acc_hit, map_err}, 16'h1);
  endtask

  task automatic t_chan_reset_narrow();
    wr(1'b0, 1'b0, 16'h0080);
    chk("R6 enter reset narrow", 16'(chan_reset), 16'h1);
    wr(1'b0, 1'b0, 16'h1200);
    chk("R6 zero low byte exits reset (8-bit)", 16'(chan_reset), 16'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      vecs++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    hw_reset();
    t_reset_state();
    t_config_mux();
    t_mux_scratch();
    t_cfg_locked();
    t_clock();
    t_chan_reset_wide();
    t_dma();
    t_port();
    t_unmapped();
    t_nonmux();
    t_chan_reset_narrow();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule